// File: doc/BRIEF.md
# Windowed Indirect Register Access Engine

This block is the target-side engine of a multi-device management slave. A host reaches it through a register port in the clause-22 style. The port carries a bus address, a register number, a write flag and 16 bits of data, plus a valid/ready pair. When the strap address is non-zero, the engine answers only at that address. There it exposes two window registers: a command word at offset 0 and a data word at offset 1. Setting the start bit in the command word launches a single read or write on an internal register bus. The target of that access is named by a device number and a register number taken from the command. The start bit reads back as a busy flag until the internal access finishes. A finished read leaves its result in the data window.

A write sequence loads the data window and then issues the command. A read sequence issues the command, polls until the busy flag drops, and then reads the data window. When the strap address is zero, no window exists. Each host access passes straight to the internal bus, and the host bus address serves as the device number.

Top module: `iwin_engine`

## Requirements
- R1: After reset the command window and the data window both read 0, and the internal request valid is low.
- R2: In windowed mode, host writes at the strap address store offset 1 into the data window and offset 0 into the command window. A command with bit 15 clear reads back unchanged and starts no internal access.
- R3: A command with bit 15 = 1, bit 12 = 1 and bits 11:10 = 1 starts an internal write. The device number comes from bits 9:5, the register number from bits 4:0, and the write data from the data window. Bit 15 of the command readback stays 1 until the cycle after internal ready is seen, and then reads 0.
- R4: A command with bit 15 = 1, bit 12 = 1 and bits 11:10 = 2 starts an internal read. The internal read data is captured into the data window in the cycle where ready is seen. This also holds when ready arrives in the first request cycle.
- R5: While a request waits for ready, valid stays high and the write flag, device, register and write data do not change.
- R6: A command-window write that arrives while busy is ignored. The command readback and the running request are unchanged.
- R7: A data-window write that arrives while busy is ignored. The data window keeps its value.
- R8: A command with bit 15 = 1 whose bit 12 is clear, or whose bits 11:10 are 0 or 3, starts no internal access. Busy reads 0 in the next readback, and bits 14:0 are kept.
- R9: In windowed mode, host reads at any other bus address return 0xFFFF, and host writes there change nothing. Reads of offsets other than 0 and 1 at the strap address return 0. The host ready is always 1 in this mode.
- R10: When the strap address is 0, every host access drives the internal bus directly. Valid, write, device (the host bus address), register and data are passed through, ready and read data are returned to the host, and the window registers are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_addr | input | 5 | Strapped bus address; 0 selects direct mode |
| h_valid | input | 1 | Host access request |
| h_write | input | 1 | Host access is a write |
| h_addr | input | 5 | Host bus address |
| h_reg | input | 5 | Host register number |
| h_wdata | input | 16 | Host write data |
| h_ready | output | 1 | Host access accepted this cycle |
| h_rdata | output | 16 | Host read data |
| ib_valid | output | 1 | Internal bus request |
| ib_write | output | 1 | Internal request is a write |
| ib_dev | output | 5 | Internal device number |
| ib_reg | output | 5 | Internal register number |
| ib_wdata | output | 16 | Internal write data |
| ib_ready | input | 1 | Internal bus completes the request |
| ib_rdata | input | 16 | Internal read data |

## Verification
The assertions assume that the strap address changes only while no windowed request is outstanding. They also assume that the internal responder raises ready only while valid is high. The bench follows both rules. Its responder holds ready low for a programmable number of cycles of an outstanding request, using a latency of 0, 3 and 8. The bench switches the strap between 5 and 0 only after polling has shown the engine idle. Host traffic at foreign addresses, and host traffic during busy, is injected deliberately, so that the ignore paths run while a request is held open.

// File: rtl/iwin_pkg.sv
`timescale 1ns/1ps
package iwin_pkg;

    localparam int WORD_W  = 16;
    localparam int FIELD_W = 5;

    typedef enum logic [1:0] {
        OPC_RSVD0 = 2'd0,
        OPC_WRITE = 2'd1,
        OPC_READ  = 2'd2,
        OPC_RSVD3 = 2'd3
    } opcode_e;

    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_ISSUE = 1'b1
    } eng_state_e;

endpackage

// File: rtl/iwin_cmd_decode.sv
`timescale 1ns/1ps
module iwin_cmd_decode
    import iwin_pkg::*;
#(
    parameter int ADDR_W = FIELD_W,
    parameter int REG_W  = FIELD_W
) (
    input  logic [REG_W+ADDR_W+1:0] cmd_low,
    output logic                    op_write,
    output logic [ADDR_W-1:0]       dev,
    output logic [REG_W-1:0]        regn
);

    localparam int OP_LSB = REG_W + ADDR_W;

    opcode_e op;

    always_comb begin
        op       = opcode_e'(cmd_low[OP_LSB +: 2]);
        op_write = (op == OPC_WRITE);
        dev      = cmd_low[REG_W +: ADDR_W];
        regn     = cmd_low[0 +: REG_W];
    end

endmodule

// File: rtl/iwin_window_regs.sv
`timescale 1ns/1ps
module iwin_window_regs
    import iwin_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int ADDR_W = FIELD_W,
    parameter int REG_W  = FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rsp_ready,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic [DATA_W-1:0] cmd_view,
    output logic [DATA_W-1:0] data_view,
    output logic              busy,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_dev,
    output logic [REG_W-1:0]  req_reg,
    output logic [DATA_W-1:0] req_wdata
);

    localparam int OP_LSB   = REG_W + ADDR_W;
    localparam int FMT_BIT  = OP_LSB + 2;
    localparam int BUSY_BIT = DATA_W - 1;

    typedef struct packed {
        eng_state_e          st;
        logic [BUSY_BIT-1:0] cmd;
        logic [DATA_W-1:0]   data;
    } win_t;

    win_t    w_d, w_q;
    opcode_e new_op;
    logic    launch_ok;

    always_comb begin
        new_op    = opcode_e'(wdata[OP_LSB +: 2]);
        launch_ok = wdata[BUSY_BIT] && wdata[FMT_BIT] &&
                    (new_op == OPC_WRITE || new_op == OPC_READ);
    end

    always_comb begin
        w_d = w_q;
        unique case (w_q.st)
            ENG_IDLE: begin
                if (wr_cmd) begin
                    w_d.cmd = wdata[BUSY_BIT-1:0];
                    if (launch_ok) begin
                        w_d.st = ENG_ISSUE;
                    end
                end
                if (wr_data) begin
                    w_d.data = wdata;
                end
            end
            ENG_ISSUE: begin
                if (rsp_ready) begin
                    w_d.st = ENG_IDLE;
                    if (!req_write) begin
                        w_d.data = rsp_rdata;
                    end
                end
            end
            default: w_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q.st   <= ENG_IDLE;
            w_q.cmd  <= '0;
            w_q.data <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    iwin_cmd_decode #(
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W)
    ) u_dec (
        .cmd_low  (w_q.cmd[OP_LSB+1:0]),
        .op_write (req_write),
        .dev      (req_dev),
        .regn     (req_reg)
    );

    assign busy      = (w_q.st == ENG_ISSUE);
    assign req_valid = busy;
    assign req_wdata = w_q.data;
    assign cmd_view  = {busy, w_q.cmd};
    assign data_view = w_q.data;

    // R5: request fields frozen while waiting for ready
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !rsp_ready |=> req_valid && $stable(req_dev) &&
        $stable(req_reg) && $stable(req_write) && $stable(req_wdata));

    // R4: read result lands in the data window
    a_r4_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && rsp_ready && !req_write |=> data_view == $past(rsp_rdata));

    // R3: busy drops right after ready
    a_r3_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && rsp_ready |=> !busy);

    // R6: command write during busy leaves the stored command alone
    a_r6_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_cmd |=> $stable(cmd_view[BUSY_BIT-1:0]));

    // R7: data write during busy leaves the data window alone
    a_r7_data_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_data && !rsp_ready |=> $stable(data_view));

    // R8: malformed command never raises busy
    a_r8_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && wr_cmd && !launch_ok |=> !busy);

endmodule

// File: rtl/iwin_host_port.sv
`timescale 1ns/1ps
module iwin_host_port
    import iwin_pkg::*;
#(
    parameter int DATA_W   = WORD_W,
    parameter int ADDR_W   = FIELD_W,
    parameter int REG_W    = FIELD_W,
    parameter int CMD_OFS  = 0,
    parameter int DATA_OFS = 1
) (
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              h_valid,
    input  logic              h_write,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [REG_W-1:0]  h_reg,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_ready,
    output logic [DATA_W-1:0] h_rdata,
    input  logic [DATA_W-1:0] cmd_view,
    input  logic [DATA_W-1:0] data_view,
    output logic              wr_cmd,
    output logic              wr_data,
    input  logic              eng_valid,
    input  logic              eng_write,
    input  logic [ADDR_W-1:0] eng_dev,
    input  logic [REG_W-1:0]  eng_reg,
    input  logic [DATA_W-1:0] eng_wdata,
    output logic              eng_ready,
    output logic              ib_valid,
    output logic              ib_write,
    output logic [ADDR_W-1:0] ib_dev,
    output logic [REG_W-1:0]  ib_reg,
    output logic [DATA_W-1:0] ib_wdata,
    input  logic              ib_ready,
    input  logic [DATA_W-1:0] ib_rdata
);

    logic direct;
    logic hit;
    logic host_wr;

    always_comb begin
        direct  = (strap_addr == '0);
        hit     = (h_addr == strap_addr);
        host_wr = h_valid && h_write && hit && !direct;

        wr_cmd  = host_wr && (h_reg == REG_W'(CMD_OFS));
        wr_data = host_wr && (h_reg == REG_W'(DATA_OFS));

        if (direct) begin
            ib_valid  = h_valid;
            ib_write  = h_write;
            ib_dev    = h_addr;
            ib_reg    = h_reg;
            ib_wdata  = h_wdata;
            h_ready   = ib_ready;
            h_rdata   = ib_rdata;
            eng_ready = 1'b0;
        end else begin
            ib_valid  = eng_valid;
            ib_write  = eng_write;
            ib_dev    = eng_dev;
            ib_reg    = eng_reg;
            ib_wdata  = eng_wdata;
            h_ready   = 1'b1;
            eng_ready = ib_ready;
            if (!hit) begin
                h_rdata = '1;
            end else if (h_reg == REG_W'(CMD_OFS)) begin
                h_rdata = cmd_view;
            end else if (h_reg == REG_W'(DATA_OFS)) begin
                h_rdata = data_view;
            end else begin
                h_rdata = '0;
            end
        end
    end

endmodule

// File: rtl/iwin_engine.sv
`timescale 1ns/1ps
module iwin_engine
    import iwin_pkg::*;
#(
    parameter int DATA_W   = WORD_W,
    parameter int ADDR_W   = FIELD_W,
    parameter int REG_W    = FIELD_W,
    parameter int CMD_OFS  = 0,
    parameter int DATA_OFS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              h_valid,
    input  logic              h_write,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [REG_W-1:0]  h_reg,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_ready,
    output logic [DATA_W-1:0] h_rdata,
    output logic              ib_valid,
    output logic              ib_write,
    output logic [ADDR_W-1:0] ib_dev,
    output logic [REG_W-1:0]  ib_reg,
    output logic [DATA_W-1:0] ib_wdata,
    input  logic              ib_ready,
    input  logic [DATA_W-1:0] ib_rdata
);

    logic [DATA_W-1:0] cmd_view;
    logic [DATA_W-1:0] data_view;
    logic              wr_cmd;
    logic              wr_data;
    logic              eng_busy;
    logic              eng_valid;
    logic              eng_write;
    logic [ADDR_W-1:0] eng_dev;
    logic [REG_W-1:0]  eng_reg;
    logic [DATA_W-1:0] eng_wdata;
    logic              eng_ready;

    iwin_window_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cmd    (wr_cmd),
        .wr_data   (wr_data),
        .wdata     (h_wdata),
        .rsp_ready (eng_ready),
        .rsp_rdata (ib_rdata),
        .cmd_view  (cmd_view),
        .data_view (data_view),
        .busy      (eng_busy),
        .req_valid (eng_valid),
        .req_write (eng_write),
        .req_dev   (eng_dev),
        .req_reg   (eng_reg),
        .req_wdata (eng_wdata)
    );

    iwin_host_port #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .REG_W    (REG_W),
        .CMD_OFS  (CMD_OFS),
        .DATA_OFS (DATA_OFS)
    ) u_port (
        .strap_addr (strap_addr),
        .h_valid    (h_valid),
        .h_write    (h_write),
        .h_addr     (h_addr),
        .h_reg      (h_reg),
        .h_wdata    (h_wdata),
        .h_ready    (h_ready),
        .h_rdata    (h_rdata),
        .cmd_view   (cmd_view),
        .data_view  (data_view),
        .wr_cmd     (wr_cmd),
        .wr_data    (wr_data),
        .eng_valid  (eng_valid),
        .eng_write  (eng_write),
        .eng_dev    (eng_dev),
        .eng_reg    (eng_reg),
        .eng_wdata  (eng_wdata),
        .eng_ready  (eng_ready),
        .ib_valid   (ib_valid),
        .ib_write   (ib_write),
        .ib_dev     (ib_dev),
        .ib_reg     (ib_reg),
        .ib_wdata   (ib_wdata),
        .ib_ready   (ib_ready),
        .ib_rdata   (ib_rdata)
    );

    // R10: the windowed engine stays quiet in direct mode
    a_r10_direct_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_addr == '0) |-> !eng_busy);

    // R9: no window strobe reaches the engine for a foreign address
    a_r9_foreign_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy && h_valid && (h_addr != strap_addr) |=> !eng_busy);

endmodule

// File: tb/test_iwin_engine.sv
`timescale 1ns/1ps
module test_iwin_engine;

    localparam logic [4:0] STRAP = 5'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap = STRAP;
    logic        h_valid = 1'b0;
    logic        h_write = 1'b0;
    logic [4:0]  h_addr = '0;
    logic [4:0]  h_reg = '0;
    logic [15:0] h_wdata = '0;
    logic        h_ready;
    logic [15:0] h_rdata;
    logic        ib_valid, ib_write;
    logic [4:0]  ib_dev, ib_reg;
    logic [15:0] ib_wdata;
    logic        ib_ready;
    logic [15:0] ib_rdata;

    int          errors = 0;
    int          checks = 0;
    string       tag = "R1";

    logic        m_busy = 1'b0;
    logic [15:0] m_cmd = '0;
    logic [15:0] m_data = '0;
    int          m_wait = 0;
    int          lat = 0;
    logic [15:0] rsp_val = '0;
    logic        dir_ready = 1'b0;
    logic        mdl_ready = 1'b0;
    logic        snap_valid;
    logic [4:0]  snap_dev;

    always #2 clk = ~clk;

    assign ib_ready = (strap == 5'd0) ? dir_ready : mdl_ready;
    assign ib_rdata = rsp_val;

    iwin_engine i_iwin_engine (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap),
        .h_valid(h_valid), .h_write(h_write), .h_addr(h_addr), .h_reg(h_reg),
        .h_wdata(h_wdata), .h_ready(h_ready), .h_rdata(h_rdata),
        .ib_valid(ib_valid), .ib_write(ib_write), .ib_dev(ib_dev), .ib_reg(ib_reg),
        .ib_wdata(ib_wdata), .ib_ready(ib_ready), .ib_rdata(ib_rdata)
    );

    task automatic chk(input string t, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd();
        if (h_addr != strap) return 16'hFFFF;
        if (h_reg == 5'd0)   return {m_busy, m_cmd[14:0]};
        if (h_reg == 5'd1)   return m_data;
        return 16'h0000;
    endfunction

    // reference model: window contents, busy flag, responder wait count
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_cmd = '0; m_data = '0; m_wait = 0;
        end else if (strap != 5'd0) begin
            if (m_busy) begin
                if (ib_ready) begin
                    if (m_cmd[11:10] == 2'd2) m_data = ib_rdata;
                    m_busy = 1'b0;
                end else begin
                    m_wait++;
                end
            end else if (h_valid && h_write && h_addr == strap) begin
                if (h_reg == 5'd0) begin
                    m_cmd = h_wdata & 16'h7FFF;
                    if (h_wdata[15] && h_wdata[12] &&
                        (h_wdata[11:10] == 2'd1 || h_wdata[11:10] == 2'd2)) begin
                        m_busy = 1'b1;
                        m_wait = 0;
                    end
                end else if (h_reg == 5'd1) begin
                    m_data = h_wdata;
                end
            end
        end
    end

    always @(posedge clk) begin
        #1;
        mdl_ready = m_busy && (m_wait >= lat);
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (strap == 5'd0) begin
                chk(tag, "ib_valid", ib_valid, h_valid);
                if (h_valid) begin
                    chk(tag, "ib_dev", ib_dev, h_addr);
                    chk(tag, "ib_reg", ib_reg, h_reg);
                    chk(tag, "ib_write", ib_write, h_write);
                    chk(tag, "h_ready", h_ready, ib_ready);
                    if (h_write) chk(tag, "ib_wdata", ib_wdata, h_wdata);
                    else         chk(tag, "h_rdata", h_rdata, ib_rdata);
                end
            end else begin
                chk(tag, "ib_valid", ib_valid, m_busy);
                if (m_busy) begin
                    chk(tag, "ib_write", ib_write, m_cmd[11:10] == 2'd1);
                    chk(tag, "ib_dev", ib_dev, m_cmd[9:5]);
                    chk(tag, "ib_reg", ib_reg, m_cmd[4:0]);
                    chk(tag, "ib_wdata", ib_wdata, m_data);
                end
                if (h_valid) begin
                    chk(tag, "h_ready", h_ready, 1'b1);
                    if (!h_write) chk(tag, "h_rdata", h_rdata, exp_rd());
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [4:0] r, input logic [15:0] d);
        @(posedge clk); #1;
        h_valid = 1'b1; h_write = 1'b1; h_addr = a; h_reg = r; h_wdata = d;
        @(posedge clk); #1;
        h_valid = 1'b0; h_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [4:0] r, output logic [15:0] v);
        @(posedge clk); #1;
        h_valid = 1'b1; h_write = 1'b0; h_addr = a; h_reg = r;
        @(negedge clk);
        v = h_rdata;
        snap_valid = ib_valid;
        snap_dev = ib_dev;
        @(posedge clk); #1;
        h_valid = 1'b0;
    endtask

    task automatic poll(output logic [15:0] v);
        v = 16'hFFFF;
        for (int n = 0; n < 40 && v[15]; n++) rd(STRAP, 5'd0, v);
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        tag = "R1";
        @(negedge clk);
        chk("R1", "ib_valid after reset", ib_valid, 1'b0);
        rd(STRAP, 5'd0, v); chk("R1", "command window", v, 16'h0000);
        rd(STRAP, 5'd1, v); chk("R1", "data window", v, 16'h0000);

        tag = "R2";
        wr(STRAP, 5'd1, 16'hA5A5);
        rd(STRAP, 5'd1, v); chk("R2", "data window", v, 16'hA5A5);
        wr(STRAP, 5'd0, 16'h1234);
        rd(STRAP, 5'd0, v); chk("R2", "command idle store", v, 16'h1234);

        tag = "R3";
        lat = 3;
        wr(STRAP, 5'd1, 16'hBEEF);
        wr(STRAP, 5'd0, 16'h94E9);
        rd(STRAP, 5'd0, v); chk("R3", "busy readback", v, 16'h94E9);
        chk("R3", "request valid", ib_valid, 1'b1);
        chk("R3", "request dev", ib_dev, 5'd7);
        chk("R3", "request reg", ib_reg, 5'd9);
        chk("R3", "request wdata", ib_wdata, 16'hBEEF);
        poll(v); chk("R3", "busy cleared", v, 16'h14E9);

        tag = "R4";
        lat = 0;
        rsp_val = 16'h3C5A;
        wr(STRAP, 5'd0, 16'h9871);
        poll(v); chk("R4", "read done", v, 16'h1871);
        rd(STRAP, 5'd1, v); chk("R4", "read data captured", v, 16'h3C5A);

        tag = "R5";
        lat = 8;
        rsp_val = 16'h0BAD;
        wr(STRAP, 5'd1, 16'h1111);
        wr(STRAP, 5'd0, 16'h94E9);
        tag = "R6";
        wr(STRAP, 5'd0, 16'h9871);
        tag = "R7";
        wr(STRAP, 5'd1, 16'h2222);
        rd(STRAP, 5'd0, v); chk("R6", "command kept while busy", v, 16'h94E9);
        chk("R7", "request wdata kept", ib_wdata, 16'h1111);
        poll(v); chk("R6", "original command finished", v, 16'h14E9);
        rd(STRAP, 5'd1, v); chk("R7", "data window kept", v, 16'h1111);

        tag = "R8";
        wr(STRAP, 5'd0, 16'h9C23);
        rd(STRAP, 5'd0, v); chk("R8", "opcode 3 no busy", v, 16'h1C23);
        wr(STRAP, 5'd0, 16'h8423);
        rd(STRAP, 5'd0, v); chk("R8", "format bit clear no busy", v, 16'h0423);
        wr(STRAP, 5'd0, 16'h9023);
        rd(STRAP, 5'd0, v); chk("R8", "opcode 0 no busy", v, 16'h1023);
        chk("R8", "no request", ib_valid, 1'b0);

        tag = "R9";
        rd(5'd6, 5'd0, v); chk("R9", "foreign read", v, 16'hFFFF);
        wr(5'd6, 5'd1, 16'h7777);
        wr(5'd6, 5'd0, 16'h94E9);
        chk("R9", "foreign command no request", ib_valid, 1'b0);
        rd(STRAP, 5'd1, v); chk("R9", "data after foreign write", v, 16'h1111);
        rd(STRAP, 5'd0, v); chk("R9", "command after foreign write", v, 16'h1023);
        rd(STRAP, 5'd3, v); chk("R9", "unused offset", v, 16'h0000);

        tag = "R10";
        @(posedge clk); #1;
        strap = 5'd0;
        dir_ready = 1'b1;
        rsp_val = 16'h4242;
        rd(5'd4, 5'd2, v); chk("R10", "direct read data", v, 16'h4242);
        chk("R10", "direct request valid", snap_valid, 1'b1);
        chk("R10", "direct device", snap_dev, 5'd4);
        wr(5'd5, 5'd1, 16'h5555);
        @(posedge clk); #1;
        strap = STRAP;
        dir_ready = 1'b0;
        tag = "R10";
        rd(STRAP, 5'd1, v); chk("R10", "window untouched by direct", v, 16'h1111);

        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule